// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block is started when a translation lookaside buffer misses. It takes a 32-bit virtual address and the table base register value. It reads one or two descriptor words from memory through a word-read port that uses a request/valid handshake. The result is either a mapping record for the TLB or a translation fault code.

The first-level word either describes a one-megabyte section directly, points to a second-level table, or is unmapped. A second-level word describes a large page or a small page, or is unmapped. For every walk the block returns the following:

- the mapping kind;
- the four-bit domain;
- the masked permission bits;
- the raw descriptor word, which the TLB trims according to the mapping kind;
- the virtual address that was walked.

While a walk is in progress, the block ignores any further start strobes.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: `walk_busy`, `mem_req` and `walk_done` are low, and `walk_fault` and `walk_kind` read 0.
- R2: The first read address is (table_base AND 0xFFFFC000) OR (va shifted right by 18), with bits [1:0] forced to 0.
- R3: First-level type bits [1:0] equal to 0 or 3 end the walk with fault code 1 (section fault). In that case there is no second read, the kind is 0, and the domain, permissions and raw word are 0.
- R4: First-level type 2 is a section. It gives kind 3, permissions = word AND 0x00000C0C, domain = word bits [8:5], raw word = the first-level word, and fault 0.
- R5: First-level type 1 leads to a second read. Its address is (first-level word AND 0xFFFFFC00) OR ((va AND 0x000FF000) shifted right by 10), with bits [1:0] equal to 0.
- R6: Second-level type bits equal to 0 or 3 give fault code 2 (page fault). The kind, permissions and raw word are 0, and the domain still carries first-level bits [8:5].
- R7: Second-level type 1 gives kind 2 (large page) and type 2 gives kind 1 (small page). In both cases permissions = second-level word AND 0x00000FFC, domain = first-level bits [8:5], raw word = the second-level word, and fault 0.
- R8: Each level issues exactly one single-cycle `mem_req`. `walk_done` is a one-cycle pulse, and `walk_va` is returned on `walk_va_out`.
- R9: A `walk_start` seen while the walker is busy is ignored. It changes neither the result nor the number of memory reads.
- R10: The walker waits any number of cycles for `mem_valid`. The result does not depend on the memory latency, and `walk_done` only follows a cycle in which `mem_valid` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| walk_start | input | 1 | Begin a walk (sampled when idle) |
| walk_va | input | 32 | Virtual address to translate |
| table_base | input | 32 | Translation table base register |
| walk_busy | output | 1 | A walk is in progress |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Word address of the descriptor |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read descriptor word |
| walk_done | output | 1 | Result strobe |
| walk_fault | output | 2 | 0 none, 1 section fault, 2 page fault |
| walk_kind | output | 2 | 0 none, 1 small page, 2 large page, 3 section |
| walk_domain | output | 4 | Domain number |
| walk_perms | output | 32 | Masked permission bits |
| walk_phys | output | 32 | Raw descriptor word for the TLB |
| walk_va_out | output | 32 | Virtual address of the finished walk |

## Verification
The bench sweeps all four first-level types against all four second-level types. It repeats this for three address/base patterns and three memory latencies, so the section, large-page, small-page and both fault paths are each reached with differing domain, permission and index bits.

The all-ones and sparse address patterns show whether each mask and shift is placed correctly. Varying the latency separates a walker that waits on `mem_valid` from one that samples the bus at a fixed cycle. A start pulse issued in the middle of a slow walk shows whether a busy walker really ignores new requests.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int ADDR_W = 32;
    localparam int DOM_W  = 4;
    localparam int DOM_LSB = 5;
    localparam int L1_SHIFT = 18;
    localparam int L2_SHIFT = 10;

    localparam logic [ADDR_W-1:0] L1_BASE_MASK   = 32'hFFFF_C000;
    localparam logic [ADDR_W-1:0] L2_BASE_MASK   = 32'hFFFF_FC00;
    localparam logic [ADDR_W-1:0] L2_INDEX_MASK  = 32'h000F_F000;
    localparam logic [ADDR_W-1:0] SEC_PERM_MASK  = 32'h0000_0C0C;
    localparam logic [ADDR_W-1:0] PAGE_PERM_MASK = 32'h0000_0FFC;
    localparam logic [ADDR_W-1:0] WORD_ALIGN     = 32'hFFFF_FFFC;

    typedef enum logic [2:0] {
        ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE
    } walk_st_e;

    typedef enum logic [1:0] {
        MAP_NONE = 2'd0, MAP_SMALL = 2'd1, MAP_LARGE = 2'd2, MAP_SECTION = 2'd3
    } map_kind_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0, FLT_SECTION = 2'd1, FLT_PAGE = 2'd2
    } flt_e;

    typedef struct packed {
        map_kind_e         kind;
        flt_e              fault;
        logic [DOM_W-1:0]  domain;
        logic [ADDR_W-1:0] perms;
        logic [ADDR_W-1:0] phys;
    } walk_res_t;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  logic [ADDR_W-1:0] va,
    input  logic [ADDR_W-1:0] ttb,
    input  logic [ADDR_W-1:0] l1_desc,
    output logic [ADDR_W-1:0] l1_addr,
    output logic [ADDR_W-1:0] l2_addr
);
    always_comb begin
        l1_addr = ((ttb & L1_BASE_MASK) | (va >> L1_SHIFT)) & WORD_ALIGN;
        l2_addr = ((l1_desc & L2_BASE_MASK) | ((va & L2_INDEX_MASK) >> L2_SHIFT)) & WORD_ALIGN;
    end
endmodule

// File: rtl/ptw_desc_decode.sv
module ptw_desc_decode
    import ptw_pkg::*;
(
    input  logic [ADDR_W-1:0] l1_desc,
    input  logic [ADDR_W-1:0] l2_desc,
    output logic              l1_table,
    output walk_res_t         l1_res,
    output walk_res_t         l2_res
);
    logic [DOM_W-1:0] l1_dom;

    always_comb begin
        l1_dom   = l1_desc[DOM_LSB +: DOM_W];
        l1_table = 1'b0;
        l1_res   = '0;
        unique case (l1_desc[1:0])
            2'b10: begin
                l1_res.kind   = MAP_SECTION;
                l1_res.fault  = FLT_NONE;
                l1_res.domain = l1_dom;
                l1_res.perms  = l1_desc & SEC_PERM_MASK;
                l1_res.phys   = l1_desc;
            end
            2'b01: l1_table = 1'b1;
            default: l1_res.fault = FLT_SECTION;
        endcase

        l2_res        = '0;
        l2_res.domain = l1_dom;
        unique case (l2_desc[1:0])
            2'b01, 2'b10: begin
                l2_res.kind  = (l2_desc[1:0] == 2'b01) ? MAP_LARGE : MAP_SMALL;
                l2_res.perms = l2_desc & PAGE_PERM_MASK;
                l2_res.phys  = l2_desc;
            end
            default: l2_res.fault = FLT_PAGE;
        endcase
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        walk_start,
    input  logic [31:0] walk_va,
    input  logic [31:0] table_base,
    output logic        walk_busy,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_valid,
    input  logic [31:0] mem_rdata,
    output logic        walk_done,
    output logic [1:0]  walk_fault,
    output logic [1:0]  walk_kind,
    output logic [3:0]  walk_domain,
    output logic [31:0] walk_perms,
    output logic [31:0] walk_phys,
    output logic [31:0] walk_va_out
);
    typedef struct packed {
        walk_st_e          st;
        logic [ADDR_W-1:0] va;
        logic [ADDR_W-1:0] ttb;
        logic [ADDR_W-1:0] l1d;
        walk_res_t         res;
    } walk_q_t;

    walk_q_t q, d;

    logic [ADDR_W-1:0] l1_addr_c, l2_addr_c, l1_sel_c;
    logic              l1_table_c;
    walk_res_t         l1_res_c, l2_res_c;

    ptw_addr_gen u_addr (
        .va      (q.va),
        .ttb     (q.ttb),
        .l1_desc (q.l1d),
        .l1_addr (l1_addr_c),
        .l2_addr (l2_addr_c)
    );

    assign l1_sel_c = (q.st == ST_L1_WAIT) ? mem_rdata : q.l1d;

    ptw_desc_decode u_dec (
        .l1_desc  (l1_sel_c),
        .l2_desc  (mem_rdata),
        .l1_table (l1_table_c),
        .l1_res   (l1_res_c),
        .l2_res   (l2_res_c)
    );

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: if (walk_start) begin
                d.st  = ST_L1_REQ;
                d.va  = walk_va;
                d.ttb = table_base;
                d.l1d = '0;
                d.res = '0;
            end
            ST_L1_REQ: d.st = ST_L1_WAIT;
            ST_L1_WAIT: if (mem_valid) begin
                d.l1d = mem_rdata;
                if (l1_table_c) d.st = ST_L2_REQ;
                else begin
                    d.res = l1_res_c;
                    d.st  = ST_DONE;
                end
            end
            ST_L2_REQ: d.st = ST_L2_WAIT;
            ST_L2_WAIT: if (mem_valid) begin
                d.res = l2_res_c;
                d.st  = ST_DONE;
            end
            ST_DONE: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        walk_busy   = (q.st != ST_IDLE);
        mem_req     = (q.st == ST_L1_REQ) || (q.st == ST_L2_REQ);
        mem_addr    = (q.st == ST_L2_REQ) ? l2_addr_c :
                      (q.st == ST_L1_REQ) ? l1_addr_c : '0;
        walk_done   = (q.st == ST_DONE);
        walk_fault  = q.res.fault;
        walk_kind   = q.res.kind;
        walk_domain = q.res.domain;
        walk_perms  = q.res.perms;
        walk_phys   = q.res.phys;
        walk_va_out = q.va;
    end

    // R8: every request lasts exactly one cycle
    p_req_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    // R8: the result strobe lasts one cycle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |=> !walk_done);
    // R10: a result only follows returned data
    p_done_after_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |-> $past(mem_valid));
    // R3: a faulted walk reports no mapping
    p_fault_no_map_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_done && walk_fault != 2'd0) |-> walk_kind == 2'd0);
    // R3: a section fault reports domain zero
    p_sec_fault_dom_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_done && walk_fault == 2'd1) |-> walk_domain == 4'd0);
    // R9: a start while busy does not end the walk early
    p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_busy && walk_start && !walk_done) |=> walk_busy);
    // R2: descriptor reads are word aligned
    p_addr_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00);
    // R5: a second read only follows a table pointer
    p_l2_after_table_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_L2_REQ) |-> ($past(mem_rdata[1:0]) == 2'b01 && $past(mem_valid)));
endmodule

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        walk_start = 1'b0;
    logic [31:0] walk_va = '0;
    logic [31:0] table_base = '0;
    logic        walk_busy, mem_req, walk_done;
    logic [31:0] mem_addr;
    logic        mem_valid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [1:0]  walk_fault, walk_kind;
    logic [3:0]  walk_domain;
    logic [31:0] walk_perms, walk_phys, walk_va_out;

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] l1v = '0, l2v = '0;
    int          lat = 0;
    logic        pend = 1'b0;
    int          cnt = 0;
    int          lvl = 0;
    int          rd_cnt = 0;
    logic [31:0] a_last = '0, a_prev = '0;

    always #10 clk = ~clk;

    pt_walker dut_i (
        .clk(clk), .rst_n(rst_n), .walk_start(walk_start), .walk_va(walk_va),
        .table_base(table_base), .walk_busy(walk_busy), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
        .walk_done(walk_done), .walk_fault(walk_fault), .walk_kind(walk_kind),
        .walk_domain(walk_domain), .walk_perms(walk_perms), .walk_phys(walk_phys),
        .walk_va_out(walk_va_out)
    );

    // memory model: answers each request after lat extra cycles
    always @(posedge clk) begin
        mem_valid <= 1'b0;
        if (pend) begin
            if (cnt == 0) begin
                mem_valid <= 1'b1;
                mem_rdata <= (lvl == 1) ? l1v : l2v;
                pend      <= 1'b0;
            end else cnt <= cnt - 1;
        end
        if (mem_req) begin
            pend   <= 1'b1;
            cnt    <= lat;
            lvl    <= lvl + 1;
            rd_cnt <= rd_cnt + 1;
            a_prev <= a_last;
            a_last <= mem_addr;
        end else if (walk_done) lvl <= 0;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_walk(input logic [31:0] va, input logic [31:0] ttb,
                            input logic [31:0] d1, input logic [31:0] d2, input int l);
        int base;
        int waited;
        logic [31:0] e1a, e2a, ephys, eperm;
        logic [1:0]  efl, ekd;
        logic [3:0]  edom;
        int          ereads;
        @(negedge clk);
        l1v = d1; l2v = d2; lat = l;
        base = rd_cnt;
        walk_va = va; table_base = ttb; walk_start = 1'b1;
        @(negedge clk);
        walk_start = 1'b0;
        waited = 0;
        while (!walk_done && waited < 60) begin
            @(negedge clk);
            waited++;
        end
        chk("R8 done seen", {31'd0, walk_done}, 32'd1);
        e1a = ((ttb & 32'hFFFFC000) | (va >> 18)) & 32'hFFFFFFFC;
        e2a = (d1 & 32'hFFFFFC00) | ((va & 32'h000FF000) >> 10);
        edom = d1[8:5];
        ereads = 1;
        if (d1[1:0] == 2'b10) begin
            efl = 2'd0; ekd = 2'd3; eperm = d1 & 32'h00000C0C; ephys = d1;
        end else if (d1[1:0] != 2'b01) begin
            efl = 2'd1; ekd = 2'd0; eperm = 0; ephys = 0; edom = 4'd0;
        end else begin
            ereads = 2;
            if (d2[1:0] == 2'b01 || d2[1:0] == 2'b10) begin
                efl = 2'd0; ekd = (d2[1:0] == 2'b01) ? 2'd2 : 2'd1;
                eperm = d2 & 32'h00000FFC; ephys = d2;
            end else begin
                efl = 2'd2; ekd = 2'd0; eperm = 0; ephys = 0;
            end
        end
        chk("R3/R6 fault code", {30'd0, walk_fault}, {30'd0, efl});
        chk("R4/R7 kind", {30'd0, walk_kind}, {30'd0, ekd});
        chk("R4/R6/R7 domain", {28'd0, walk_domain}, {28'd0, edom});
        chk("R4/R7 perms", walk_perms, eperm);
        chk("R4/R7 phys", walk_phys, ephys);
        chk("R8 va out", walk_va_out, va);
        chk("R8 read count", rd_cnt - base, ereads);
        if (ereads == 1) chk("R2 l1 addr", a_last, e1a);
        else begin
            chk("R2 l1 addr", a_prev, e1a);
            chk("R5 l2 addr", a_last, e2a);
        end
        @(negedge clk);
        chk("R8 done pulse", {31'd0, walk_done}, 32'd0);
        chk("R8 idle after", {31'd0, walk_busy}, 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] va, ttb, d1, d2;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", {31'd0, walk_busy}, 0);
        chk("R1 req", {31'd0, mem_req}, 0);
        chk("R1 done", {31'd0, walk_done}, 0);
        chk("R1 fault", {30'd0, walk_fault}, 0);
        chk("R1 kind", {30'd0, walk_kind}, 0);
        rst_n = 1'b1;
        // R2..R7, R10 sweep
        for (int p = 0; p < 3; p++) begin
            case (p)
                0: begin va = 32'hFFFFFFFF; ttb = 32'hFFFFFFFF; end
                1: begin va = 32'h12345678; ttb = 32'h0000C000; end
                default: begin va = 32'h80F03ABC; ttb = 32'hABCDE123; end
            endcase
            for (int t1 = 0; t1 < 4; t1++)
                for (int t2 = 0; t2 < 4; t2++)
                    for (int l = 0; l < 3; l++) begin
                        d1 = ((32'h9E3779B1 * (p + 3 * t2 + 1)) & 32'hFFFFFFFC) | t1;
                        d2 = ((32'h7F4A7C15 * (p + 5 * t1 + 2)) & 32'hFFFFFFFC) | t2;
                        run_walk(va, ttb, d1, d2, l);
                    end
        end
        // R9: a start during a slow walk is ignored
        begin
            int base;
            int waited;
            @(negedge clk);
            l1v = 32'h00400021 | 32'h000001E0; l2v = 32'h5555AAA6; lat = 6;
            base = rd_cnt;
            walk_va = 32'h00ABC000; table_base = 32'h00010000; walk_start = 1'b1;
            @(negedge clk);
            walk_start = 1'b0;
            repeat (3) @(negedge clk);
            walk_va = 32'hDEAD0000; walk_start = 1'b1;
            @(negedge clk);
            walk_start = 1'b0;
            waited = 0;
            while (!walk_done && waited < 60) begin
                @(negedge clk);
                waited++;
            end
            chk("R9 va kept", walk_va_out, 32'h00ABC000);
            chk("R9 kind", {30'd0, walk_kind}, 32'd1);
            chk("R9 phys", walk_phys, 32'h5555AAA6);
            repeat (6) @(negedge clk);
            chk("R9 reads", rd_cnt - base, 2);
            chk("R9 idle", {31'd0, walk_busy}, 0);
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule